// File: doc/BRIEF.md
# Effective Address Generator with Cycle Penalty

This block is purely combinational. It forms the 16-bit effective address that an 8-bit processor's execute stage uses for a memory operand. The sequencer supplies a 4-bit addressing-mode code, the one or two operand bytes of the instruction and the X and Y index registers. It also supplies the program counter value that already points past the operand bytes and, for pointer-based modes, the two pointer bytes it fetched. The block returns four results: the effective address, the address where the pointer bytes must be fetched, the instruction length in bytes, and the number of extra cycles the instruction costs.

Fetching memory is not part of this block. The sequencer first reads `ptr_addr_o`. It fetches the low pointer byte from that address and the high byte from the next address, because pointers are stored low byte first. It then presents both bytes on `ptr_lo_i`/`ptr_hi_i`, and the effective address becomes valid.

Extra cycles arise only in three cases: indexed addressing that carries into a new 256-byte page, a taken branch, and a taken branch whose target lies on another page.

Top module: `eag_top`

## Requirements
- R1: Mode code 3 (zero page) gives an effective address of {8'h00, op_lo}, with length 2.
- R2: Mode codes 4 (zero page + X) and 5 (zero page + Y) give {8'h00, (op_lo + index) mod 256}. The sum wraps inside page zero, and the length is 2.
- R3: Mode code 6 (absolute) treats the operand as little-endian and gives {op_hi, op_lo}, with length 3.
- R4: Mode codes 7 (absolute + X) and 8 (absolute + Y) add the index to {op_hi, op_lo} modulo 2^16. They report 1 extra cycle when the high byte of the result differs from op_hi, and 0 otherwise. The length is 3.
- R5: Mode code 9 (indexed indirect) gives ptr_addr = {8'h00, (op_lo + X) mod 256} and an effective address of {ptr_hi, ptr_lo}. The length is 2 and there are no extra cycles.
- R6: Mode code 10 (indirect indexed) gives ptr_addr = {8'h00, op_lo} and an effective address of {ptr_hi, ptr_lo} + Y modulo 2^16. It reports 1 extra cycle when the result's high byte differs from ptr_hi. The length is 2.
- R7: Mode code 11 (indirect) gives ptr_addr = {op_hi, op_lo} and an effective address of {ptr_hi, ptr_lo}. The length is 3.
- R8: Mode code 2 (immediate) gives pc_next - 1, the address of the immediate byte, with length 2.
- R9: Mode code 12 (relative) gives pc_next plus op_lo read as a signed two's-complement byte, modulo 2^16. The length is 2.
- R10: In mode code 12, extra cycles are 0 when branch_taken is low. When branch_taken is high they are 1, or 2 if the target's high byte differs from pc_next's high byte.
- R11: Extra cycles are 0 for every mode code other than 7, 8, 10 and 12.
- R12: ptr_addr is 0 for every mode code other than 9, 10 and 11.
- R13: Mode codes 0 (implied), 1 (accumulator) and the unused codes 13 to 15 give an effective address of 0 and a length of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 4 | Addressing-mode code (see requirements) |
| op_lo_i | input | 8 | First operand byte (low byte, offset or zero-page address) |
| op_hi_i | input | 8 | Second operand byte (high byte) |
| idx_x_i | input | 8 | X index register |
| idx_y_i | input | 8 | Y index register |
| pc_next_i | input | 16 | Program counter pointing past the operand bytes |
| ptr_lo_i | input | 8 | Pointer low byte fetched from ptr_addr_o |
| ptr_hi_i | input | 8 | Pointer high byte fetched from ptr_addr_o + 1 |
| branch_taken_i | input | 1 | Branch condition is met (relative mode only) |
| ea_o | output | 16 | Effective address |
| ptr_addr_o | output | 16 | Address of the pointer's low byte |
| extra_cyc_o | output | 2 | Extra cycles beyond the base count |
| instr_len_o | output | 2 | Instruction length in bytes |

## Verification
The embedded assertions are re-evaluated whenever an input changes. They check four properties on every evaluation:
- a page carry in each index adder always coincides with a change of the high byte;
- zero-page modes never leave page zero;
- extra cycles appear only in the indexed and branch modes;
- an untaken branch costs nothing, while a taken one always costs at least a cycle.

Exact address values need the bench's scenarios, because the assertions cannot show them. These include the wrap at 0xFF in page zero, the 0xFFFF-to-0x0000 rollover, backward branch offsets, the two-cycle cross-page branch and the per-mode instruction length.

// File: rtl/eag_pkg.sv
package eag_pkg;

  // Addressing-mode codes; codes above AM_REL behave as implied.
  typedef enum logic [3:0] {
    AM_IMPL = 4'd0,
    AM_ACC  = 4'd1,
    AM_IMM  = 4'd2,
    AM_ZP   = 4'd3,
    AM_ZPX  = 4'd4,
    AM_ZPY  = 4'd5,
    AM_ABS  = 4'd6,
    AM_ABSX = 4'd7,
    AM_ABSY = 4'd8,
    AM_INDX = 4'd9,
    AM_INDY = 4'd10,
    AM_IND  = 4'd11,
    AM_REL  = 4'd12
  } amode_e;

  localparam int LEN_W   = 2;
  localparam int EXTRA_W = 2;

endpackage

// File: rtl/eag_index_add.sv
module eag_index_add #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [BYTE_W-1:0] index_i,
  output logic [ADDR_W-1:0] sum_o,
  output logic              page_carry_o
);
  localparam int PAGE_W = ADDR_W - BYTE_W;

  // low-byte add with carry out; the carry is the page-crossing event
  function automatic logic [BYTE_W:0] low_add(input logic [BYTE_W-1:0] a,
                                              input logic [BYTE_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [BYTE_W:0] low_sum;
  logic [PAGE_W-1:0] page_sum;

  always_comb begin
    low_sum      = low_add(base_i[BYTE_W-1:0], index_i);
    page_sum     = base_i[ADDR_W-1:BYTE_W] + PAGE_W'(low_sum[BYTE_W]);
    sum_o        = {page_sum, low_sum[BYTE_W-1:0]};
    page_carry_o = low_sum[BYTE_W];
  end

  always_comb begin
    AST_CARRY_MEANS_NEW_PAGE: assert (page_carry_o == (sum_o[ADDR_W-1:BYTE_W] != base_i[ADDR_W-1:BYTE_W])); // R4
  end

endmodule

// File: rtl/eag_zp_wrap.sv
module eag_zp_wrap #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] base_i,
  input  logic [BYTE_W-1:0] index_i,
  output logic [ADDR_W-1:0] zp_addr_o
);
  localparam int PAGE_W = ADDR_W - BYTE_W;

  // sum truncated to a byte: the address never leaves page zero
  function automatic logic [BYTE_W-1:0] wrap_add(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
    return a + b;
  endfunction

  assign zp_addr_o = {{PAGE_W{1'b0}}, wrap_add(base_i, index_i)};

  always_comb begin
    AST_ZP_WRAP_PAGE_ZERO: assert (zp_addr_o[ADDR_W-1:BYTE_W] == '0); // R2
  end

endmodule

// File: rtl/eag_branch.sv
module eag_branch #(
  parameter int ADDR_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int EXTRA_W = 2
) (
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [BYTE_W-1:0]  offset_i,
  input  logic               taken_i,
  output logic [ADDR_W-1:0]  target_o,
  output logic               far_o,
  output logic [EXTRA_W-1:0] extra_o
);
  function automatic logic [ADDR_W-1:0] sext(input logic [BYTE_W-1:0] v);
    return {{(ADDR_W-BYTE_W){v[BYTE_W-1]}}, v};
  endfunction

  function automatic logic page_changed(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:BYTE_W] != b[ADDR_W-1:BYTE_W];
  endfunction

  always_comb begin
    target_o = pc_i + sext(offset_i);
    far_o    = page_changed(target_o, pc_i);
    if (taken_i) extra_o = far_o ? EXTRA_W'(2) : EXTRA_W'(1);
    else         extra_o = '0;
  end

  always_comb begin
    AST_UNTAKEN_FREE: assert (taken_i || extra_o == '0); // R10
    AST_TAKEN_COSTS:  assert (!taken_i || extra_o != '0); // R10
  end

endmodule

// File: rtl/eag_top.sv
module eag_top #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [3:0]        mode_i,
  input  logic [BYTE_W-1:0] op_lo_i,
  input  logic [BYTE_W-1:0] op_hi_i,
  input  logic [BYTE_W-1:0] idx_x_i,
  input  logic [BYTE_W-1:0] idx_y_i,
  input  logic [ADDR_W-1:0] pc_next_i,
  input  logic [BYTE_W-1:0] ptr_lo_i,
  input  logic [BYTE_W-1:0] ptr_hi_i,
  input  logic              branch_taken_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] ptr_addr_o,
  output logic [1:0]        extra_cyc_o,
  output logic [1:0]        instr_len_o
);
  import eag_pkg::*;

  localparam int PAGE_W = ADDR_W - BYTE_W;

  amode_e mode;
  assign mode = amode_e'(mode_i);

  // operand and pointer joined little-endian
  logic [ADDR_W-1:0] operand16, pointer16;
  assign operand16 = {op_hi_i, op_lo_i};
  assign pointer16 = {ptr_hi_i, ptr_lo_i};

  // zero-page paths: direct indexing by X/Y, and the X pre-index for pointers
  logic [BYTE_W-1:0] zp_index;
  logic [ADDR_W-1:0] zp_indexed, zp_ptr_x;
  assign zp_index = (mode == AM_ZPY) ? idx_y_i : idx_x_i;

  eag_zp_wrap #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_zp_idx (
    .base_i(op_lo_i), .index_i(zp_index), .zp_addr_o(zp_indexed));
  eag_zp_wrap #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_zp_ptr (
    .base_i(op_lo_i), .index_i(idx_x_i), .zp_addr_o(zp_ptr_x));

  // full-width index adders with page carry
  logic [BYTE_W-1:0] abs_index;
  logic [ADDR_W-1:0] abs_sum, indy_sum;
  logic              abs_cross, indy_cross;
  assign abs_index = (mode == AM_ABSY) ? idx_y_i : idx_x_i;

  eag_index_add #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_abs_add (
    .base_i(operand16), .index_i(abs_index),
    .sum_o(abs_sum), .page_carry_o(abs_cross));
  eag_index_add #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_indy_add (
    .base_i(pointer16), .index_i(idx_y_i),
    .sum_o(indy_sum), .page_carry_o(indy_cross));

  // branch target and penalty
  logic [ADDR_W-1:0]  br_target;
  logic               br_far;
  logic [EXTRA_W-1:0] br_extra;

  eag_branch #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .EXTRA_W(EXTRA_W)) u_branch (
    .pc_i(pc_next_i), .offset_i(op_lo_i), .taken_i(branch_taken_i),
    .target_o(br_target), .far_o(br_far), .extra_o(br_extra));

  // result selection by mode
  always_comb begin
    ea_o        = '0;
    ptr_addr_o  = '0;
    extra_cyc_o = '0;
    instr_len_o = 2'd1;
    case (mode)
      AM_IMM: begin
        ea_o        = pc_next_i - ADDR_W'(1);
        instr_len_o = 2'd2;
      end
      AM_ZP: begin
        ea_o        = {{PAGE_W{1'b0}}, op_lo_i};
        instr_len_o = 2'd2;
      end
      AM_ZPX, AM_ZPY: begin
        ea_o        = zp_indexed;
        instr_len_o = 2'd2;
      end
      AM_ABS: begin
        ea_o        = operand16;
        instr_len_o = 2'd3;
      end
      AM_ABSX, AM_ABSY: begin
        ea_o        = abs_sum;
        extra_cyc_o = {1'b0, abs_cross};
        instr_len_o = 2'd3;
      end
      AM_INDX: begin
        ptr_addr_o  = zp_ptr_x;
        ea_o        = pointer16;
        instr_len_o = 2'd2;
      end
      AM_INDY: begin
        ptr_addr_o  = {{PAGE_W{1'b0}}, op_lo_i};
        ea_o        = indy_sum;
        extra_cyc_o = {1'b0, indy_cross};
        instr_len_o = 2'd2;
      end
      AM_IND: begin
        ptr_addr_o  = operand16;
        ea_o        = pointer16;
        instr_len_o = 2'd3;
      end
      AM_REL: begin
        ea_o        = br_target;
        extra_cyc_o = br_extra;
        instr_len_o = 2'd2;
      end
      default: ;
    endcase
  end

  always_comb begin
    AST_ZP_STAYS_LOW: assert (!(mode inside {AM_ZP, AM_ZPX, AM_ZPY}) || ea_o[ADDR_W-1:BYTE_W] == '0); // R1
    AST_EXTRA_SCOPE: assert (extra_cyc_o == '0 || mode inside {AM_ABSX, AM_ABSY, AM_INDY, AM_REL}); // R11
    AST_INDY_PENALTY_PAGE: assert (!(mode == AM_INDY && extra_cyc_o != '0) || ea_o[ADDR_W-1:BYTE_W] != ptr_hi_i); // R6
    AST_FAR_TAKEN_TWO: assert (!(mode == AM_REL && branch_taken_i && br_far) || extra_cyc_o == 2'd2); // R10
    AST_PTR_SCOPE: assert (ptr_addr_o == '0 || mode inside {AM_INDX, AM_INDY, AM_IND}); // R12
  end

endmodule

// File: tb/test_eag_top.sv
module test_eag_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [3:0]  mode;
  logic [7:0]  op_lo, op_hi, ix, iy, p_lo, p_hi;
  logic [15:0] pc;
  logic        taken;
  logic [15:0] ea, paddr;
  logic [1:0]  extra, len;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  eag_top i_eag_top (
    .mode_i(mode), .op_lo_i(op_lo), .op_hi_i(op_hi), .idx_x_i(ix), .idx_y_i(iy),
    .pc_next_i(pc), .ptr_lo_i(p_lo), .ptr_hi_i(p_hi), .branch_taken_i(taken),
    .ea_o(ea), .ptr_addr_o(paddr), .extra_cyc_o(extra), .instr_len_o(len));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // independent integer model of the requirements
  task automatic model(input int m, input int ol, input int oh, input int x, input int y,
                       input int p, input int pl, input int ph, input int tk,
                       output int e, output int pa, output int ex, output int ln);
    int base, off;
    e = 0; pa = 0; ex = 0; ln = 1;
    case (m)
      2: begin e = (p + 65535) % 65536; ln = 2; end
      3: begin e = ol; ln = 2; end
      4: begin e = (ol + x) % 256; ln = 2; end
      5: begin e = (ol + y) % 256; ln = 2; end
      6: begin e = oh * 256 + ol; ln = 3; end
      7, 8: begin
        base = oh * 256 + ol;
        e  = (base + ((m == 7) ? x : y)) % 65536;
        ex = (e / 256 != oh) ? 1 : 0;
        ln = 3;
      end
      9:  begin pa = (ol + x) % 256; e = ph * 256 + pl; ln = 2; end
      10: begin
        pa = ol;
        e  = (ph * 256 + pl + y) % 65536;
        ex = (e / 256 != ph) ? 1 : 0;
        ln = 2;
      end
      11: begin pa = oh * 256 + ol; e = ph * 256 + pl; ln = 3; end
      12: begin
        off = (ol >= 128) ? ol - 256 : ol;
        e   = (p + off + 65536) % 65536;
        ex  = (tk == 0) ? 0 : ((e / 256 != p / 256) ? 2 : 1);
        ln  = 2;
      end
      default: ;
    endcase
  endtask

  task automatic run(input string req, input int m, input int ol, input int oh,
                     input int x, input int y, input int p, input int pl,
                     input int ph, input int tk);
    int e, pa, ex, ln;
    @(negedge clk);
    mode = 4'(m); op_lo = 8'(ol); op_hi = 8'(oh); ix = 8'(x); iy = 8'(y);
    pc = 16'(p); p_lo = 8'(pl); p_hi = 8'(ph); taken = 1'(tk);
    #1;
    model(m, ol, oh, x, y, p, pl, ph, tk, e, pa, ex, ln);
    check(req, "ea", int'(ea), e);
    check(req, "ptr_addr", int'(paddr), pa);
    check(req, "extra", int'(extra), ex);
    check(req, "len", int'(len), ln);
  endtask

  task automatic t_idle();
    run("R13", 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_zero_page();
    run("R1", 3, 'h42, 'h99, 'h10, 'h20, 'h1234, 0, 0, 0);
    run("R2", 4, 'hF0, 'h55, 'h20, 'h00, 0, 0, 0, 0);
    run("R2", 5, 'hFF, 'h00, 'h00, 'h01, 0, 0, 0, 0);
    run("R2", 4, 'h10, 'h00, 'h05, 'hEE, 0, 0, 0, 0);
  endtask

  task automatic t_absolute();
    run("R3", 6, 'h12, 'h34, 'h01, 'h01, 0, 0, 0, 0);
    run("R4", 7, 'h80, 'h12, 'h10, 'hFF, 0, 0, 0, 0);
    run("R4", 7, 'hF0, 'h12, 'h20, 'h00, 0, 0, 0, 0);
    run("R4", 8, 'hF0, 'hFF, 'h00, 'h20, 0, 0, 0, 0);
    run("R4", 8, 'h00, 'h40, 'hFF, 'hFF, 0, 0, 0, 0);
  endtask

  task automatic t_pointers();
    run("R5", 9, 'hFE, 'h77, 'h03, 'h00, 0, 'hCD, 'hAB, 0);
    run("R6", 10, 'h40, 'h77, 'h99, 'h10, 0, 'h20, 'h30, 0);
    run("R6", 10, 'h40, 'h00, 'h00, 'h20, 0, 'hF0, 'h30, 0);
    run("R6", 10, 'hFF, 'h00, 'h00, 'h01, 0, 'hFF, 'hFF, 0);
    run("R7", 11, 'hFF, 'h02, 'h05, 'h05, 0, 'h00, 'h80, 0);
  endtask

  task automatic t_immediate();
    run("R8", 2, 'h11, 'h22, 0, 0, 'h0601, 0, 0, 0);
    run("R8", 2, 0, 0, 0, 0, 'h0000, 0, 0, 0);
  endtask

  task automatic t_branch();
    run("R9", 12, 'h10, 0, 0, 0, 'h0300, 0, 0, 1);
    run("R9", 12, 'hFE, 0, 0, 0, 'h0310, 0, 0, 1);
    run("R10", 12, 'h80, 0, 0, 0, 'h0310, 0, 0, 1);
    run("R10", 12, 'h7F, 0, 0, 0, 'h03F0, 0, 0, 1);
    run("R10", 12, 'h7F, 0, 0, 0, 'h03F0, 0, 0, 0);
    run("R10", 12, 'h05, 0, 0, 0, 'hFFFE, 0, 0, 1);
  endtask

  task automatic t_no_penalty();
    run("R11", 6, 'hFF, 'hFF, 'hFF, 'hFF, 'hFFFF, 'hFF, 'hFF, 1);
    run("R11", 9, 'hFF, 'hFF, 'hFF, 'hFF, 'hFFFF, 'hFF, 'hFF, 1);
    run("R12", 4, 'h80, 'h80, 'h80, 'h80, 'h8080, 'h80, 'h80, 1);
    run("R13", 1, 'hAA, 'hBB, 'h01, 'h02, 'h1234, 'h55, 'h66, 1);
    run("R13", 13, 'hAA, 'hBB, 'h01, 'h02, 'h1234, 'h55, 'h66, 1);
    run("R13", 15, 'hAA, 'hBB, 'h01, 'h02, 'h1234, 'h55, 'h66, 1);
  endtask

  initial begin
    mode = '0; op_lo = '0; op_hi = '0; ix = '0; iy = '0;
    pc = '0; p_lo = '0; p_hi = '0; taken = 1'b0;
    repeat (3) @(posedge clk);
    t_idle();
    t_zero_page();
    t_absolute();
    t_pointers();
    t_immediate();
    t_branch();
    t_no_penalty();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule